// File: doc/BRIEF.md
# State-Gated SCSI Command Decoder

This block sits behind the host register interface of a SCSI bus controller. It accepts one 8-bit command byte per `cmd_valid_i` strobe and removes the DMA qualifier in bit 7. It then checks the remaining 7-bit code against the connection state, which is either disconnected or connected as initiator. A command that the state allows either takes effect at once (no-op, FIFO flush, chip reset, bus reset, reselection enable and disable, ATN set and clear) or launches a bus action through `start_o`. Any other command is rejected as illegal.

Launched actions stand for arbitration, selection and the information-transfer phases, none of which are built here. Each one ends when `done_i` arrives, and `done_ok_i` reports whether the target responded. That outcome, the command decode itself and an external reselection event all feed an 8-bit interrupt status register. The register is sticky until the host reads it. The interrupt pin is high whenever any status bit is set.

Top module: `scsi_cmd_decoder`

## Requirements
- R1: After reset the interrupt status is 0x00, `irq_o` is low, the block is disconnected and not busy, and `atn_o`, `start_o`, `flush_o` and `bus_rst_o` are low.
- R2: Bit 7 of the command byte is a DMA qualifier. It does not change the decode. When a command launches an action, `act_dma_o` carries bit 7 and `act_code_o` carries bits 6:0.
- R3: Codes 0x00 (no-op), 0x01 (FIFO flush, one-cycle `flush_o` pulse), 0x02 (chip reset) and 0x03 (bus reset, one-cycle `bus_rst_o` pulse) are accepted in every state, including while an action is pending.
- R4: Codes 0x40, 0x41, 0x42, 0x43 and 0x46 (reselect or select actions), 0x44 (enable reselection) and 0x45 (disable reselection) are legal only while disconnected. While connected they set the illegal bit (0x40) and change nothing else.
- R5: Codes 0x10, 0x11, 0x12 and 0x18 (transfer actions), 0x1A (set ATN) and 0x1B (clear ATN) are legal only while connected. Any unlisted code is always illegal. A state-gated command issued while an action is pending is illegal. An illegal command sets bit 0x40 and changes neither the connection state nor the pending action.
- R6: A bus reset forces the disconnected state and drops any pending action. It sets status bit 0x80 only when `rst_int_dis_i` is low.
- R7: Codes 0x44, 0x1A and 0x1B complete without setting any status bit. 0x44 arms reselection acceptance. 0x45 disarms it and sets function complete (0x08). 0x1A raises `atn_o` and 0x1B lowers it.
- R8: A select or reselect launch pulses `start_o` for one cycle and sets `busy_o`. A later `done_i` with `done_ok_i` high moves the block to connected and sets 0x18 (bus service and function complete). With `done_ok_i` low the block stays disconnected and sets 0x20 (disconnect).
- R9: An initiator launch pulses `start_o` and sets `busy_o`. A successful `done_i` sets 0x08 for code 0x11 and 0x10 for the other transfer codes. A failed `done_i` sets 0x20, forces disconnected and clears `atn_o`.
- R10: `reselect_i` moves the block to connected and sets 0x04 only when the block is disconnected, idle and armed, and no command is strobed in the same cycle. Otherwise it is ignored.
- R11: Chip reset (0x02) forces disconnected, drops any pending action, clears `atn_o` and the reselection arm, and clears every interrupt status bit.
- R12: A high `rd_i` clears the status register at the next edge. A bit set in that same cycle survives. `irq_o` is the OR of all status bits.
- R13: Every status bit, state output and pulse caused by a strobe is visible right after the clock edge that samples the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Command byte strobe |
| cmd_i | input | 8 | Command byte, bit 7 = DMA qualifier |
| rst_int_dis_i | input | 1 | Suppresses the bus-reset interrupt |
| done_i | input | 1 | Pending bus action finished |
| done_ok_i | input | 1 | Target responded during the finished action |
| reselect_i | input | 1 | Reselection detected on the bus |
| rd_i | input | 1 | Host read of the status register (clears it) |
| start_o | output | 1 | One-cycle launch pulse for a bus action |
| act_code_o | output | 7 | Code of the launched action |
| act_dma_o | output | 1 | DMA qualifier of the launched action |
| flush_o | output | 1 | One-cycle FIFO flush pulse |
| bus_rst_o | output | 1 | One-cycle bus reset pulse |
| atn_o | output | 1 | ATN line request |
| busy_o | output | 1 | Action pending |
| connected_o | output | 1 | Connected as initiator |
| int_stat_o | output | 8 | Interrupt status register |
| irq_o | output | 1 | Interrupt request |

## Verification
All results are registered once. A command, completion or reselection strobed before edge N appears on the status register, the state outputs and the pulse outputs right after edge N, and the pulses fall again at edge N+1. The bench drives every strobe for exactly one cycle from the falling edge. It samples at the very next falling edge, which is where each R13 result is due and which is the only window in which the pulses can be seen. A status read then takes one more cycle, and the cleared value is checked at the falling edge after it.

// File: rtl/scsi_cmd_pkg.sv
package scsi_cmd_pkg;
  localparam int CMD_W  = 8;
  localparam int CODE_W = CMD_W - 1;
  localparam int INT_W  = 8;

  // status bit positions (host software decodes these)
  localparam int IB_BUSRST = 7;
  localparam int IB_ILL    = 6;
  localparam int IB_DISC   = 5;
  localparam int IB_SVC    = 4;
  localparam int IB_FC     = 3;
  localparam int IB_RESEL  = 2;
  localparam int IB_SELATN = 1;
  localparam int IB_SEL    = 0;

  localparam logic [CODE_W-1:0] C_CMPL_SEQ = 7'h11;

  typedef enum logic {ST_DISC, ST_INIT} conn_e;

  typedef enum logic [1:0] {CL_ANY, CL_DISC, CL_INIT, CL_BAD} cls_e;

  typedef enum logic [3:0] {
    K_NOP, K_FLUSH, K_CHIPRST, K_BUSRST, K_LAUNCH,
    K_RESEL_EN, K_RESEL_DIS, K_ATN_SET, K_ATN_CLR, K_BAD
  } kind_e;
endpackage

// File: rtl/scsi_cmd_classify.sv
module scsi_cmd_classify
  import scsi_cmd_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  output cls_e              cls_o,
  output kind_e             kind_o
);
  always_comb begin
    cls_o  = CL_BAD;
    kind_o = K_BAD;
    case (code_i)
      7'h00: begin cls_o = CL_ANY;  kind_o = K_NOP;       end
      7'h01: begin cls_o = CL_ANY;  kind_o = K_FLUSH;     end
      7'h02: begin cls_o = CL_ANY;  kind_o = K_CHIPRST;   end
      7'h03: begin cls_o = CL_ANY;  kind_o = K_BUSRST;    end
      7'h40, 7'h41, 7'h42, 7'h43, 7'h46:
             begin cls_o = CL_DISC; kind_o = K_LAUNCH;    end
      7'h44: begin cls_o = CL_DISC; kind_o = K_RESEL_EN;  end
      7'h45: begin cls_o = CL_DISC; kind_o = K_RESEL_DIS; end
      7'h10, 7'h11, 7'h12, 7'h18:
             begin cls_o = CL_INIT; kind_o = K_LAUNCH;    end
      7'h1A: begin cls_o = CL_INIT; kind_o = K_ATN_SET;   end
      7'h1B: begin cls_o = CL_INIT; kind_o = K_ATN_CLR;   end
      default: ;
    endcase
  end
endmodule

// File: rtl/scsi_conn_fsm.sv
module scsi_conn_fsm
  import scsi_cmd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              dma_i,
  input  cls_e              cls_i,
  input  kind_e             kind_i,
  input  logic              rst_int_dis_i,
  input  logic              done_i,
  input  logic              done_ok_i,
  input  logic              reselect_i,
  output logic              start_o,
  output logic [CODE_W-1:0] act_code_o,
  output logic              act_dma_o,
  output logic              flush_o,
  output logic              bus_rst_o,
  output logic              atn_o,
  output logic              busy_o,
  output logic              connected_o,
  output logic [INT_W-1:0]  int_set_o,
  output logic              int_clr_all_o
);
  conn_e             state_q;
  logic              busy_q, pend_init_q, atn_q, resel_en_q;
  logic              start_q, flush_q, busrst_q, act_dma_q;
  logic [CODE_W-1:0] act_code_q;
  logic              legal, fin, resel_hit, acc;

  // state-gated commands need an idle block; anytime commands never wait
  always_comb begin
    legal = 1'b0;
    unique case (cls_i)
      CL_ANY:  legal = 1'b1;
      CL_DISC: legal = !busy_q && state_q == ST_DISC;
      CL_INIT: legal = !busy_q && state_q == ST_INIT;
      default: legal = 1'b0;
    endcase
  end

  assign acc       = cmd_valid_i && legal;
  assign fin       = busy_q && done_i;
  assign resel_hit = reselect_i && !cmd_valid_i && !busy_q &&
                     resel_en_q && state_q == ST_DISC;

  always_comb begin
    int_set_o = '0;
    if (fin) begin
      if (!done_ok_i)                    int_set_o[IB_DISC] = 1'b1;
      else if (!pend_init_q) begin
        int_set_o[IB_SVC] = 1'b1;
        int_set_o[IB_FC]  = 1'b1;
      end
      else if (act_code_q == C_CMPL_SEQ) int_set_o[IB_FC]   = 1'b1;
      else                               int_set_o[IB_SVC]  = 1'b1;
    end
    if (resel_hit) int_set_o[IB_RESEL] = 1'b1;
    if (cmd_valid_i && !legal) int_set_o[IB_ILL] = 1'b1;
    if (acc && kind_i == K_BUSRST && !rst_int_dis_i) int_set_o[IB_BUSRST] = 1'b1;
    if (acc && kind_i == K_RESEL_DIS) int_set_o[IB_FC] = 1'b1;
  end

  assign int_clr_all_o = acc && kind_i == K_CHIPRST;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_DISC;
      busy_q      <= 1'b0;
      pend_init_q <= 1'b0;
      atn_q       <= 1'b0;
      resel_en_q  <= 1'b0;
      start_q     <= 1'b0;
      flush_q     <= 1'b0;
      busrst_q    <= 1'b0;
      act_dma_q   <= 1'b0;
      act_code_q  <= '0;
    end else begin
      start_q  <= 1'b0;
      flush_q  <= 1'b0;
      busrst_q <= 1'b0;
      if (fin) begin
        busy_q <= 1'b0;
        if (!pend_init_q && done_ok_i) state_q <= ST_INIT;
        if (pend_init_q && !done_ok_i) begin
          state_q <= ST_DISC;
          atn_q   <= 1'b0;
        end
      end
      if (resel_hit) state_q <= ST_INIT;
      if (acc) begin
        unique case (kind_i)
          K_FLUSH: flush_q <= 1'b1;
          K_CHIPRST: begin
            state_q    <= ST_DISC;
            busy_q     <= 1'b0;
            atn_q      <= 1'b0;
            resel_en_q <= 1'b0;
          end
          K_BUSRST: begin
            busrst_q <= 1'b1;
            state_q  <= ST_DISC;
            busy_q   <= 1'b0;
            atn_q    <= 1'b0;
          end
          K_LAUNCH: begin
            start_q     <= 1'b1;
            busy_q      <= 1'b1;
            act_code_q  <= code_i;
            act_dma_q   <= dma_i;
            pend_init_q <= (cls_i == CL_INIT);
          end
          K_RESEL_EN:  resel_en_q <= 1'b1;
          K_RESEL_DIS: resel_en_q <= 1'b0;
          K_ATN_SET:   atn_q      <= 1'b1;
          K_ATN_CLR:   atn_q      <= 1'b0;
          default: ;
        endcase
      end
    end
  end

  assign start_o     = start_q;
  assign act_code_o  = act_code_q;
  assign act_dma_o   = act_dma_q;
  assign flush_o     = flush_q;
  assign bus_rst_o   = busrst_q;
  assign atn_o       = atn_q;
  assign busy_o      = busy_q;
  assign connected_o = (state_q == ST_INIT);

  AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> busy_o) else $error("start without busy"); // R8
  AST_SEL_FROM_DISC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o && act_code_o[6] |-> !connected_o) else $error("select while connected"); // R4
  AST_XFER_WHEN_CONN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o && !act_code_o[6] |-> connected_o) else $error("transfer while disconnected"); // R5
  AST_NO_ATN_DISC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !connected_o |-> !atn_o) else $error("ATN while disconnected"); // R9
  AST_BUSRST_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rst_o |-> !connected_o && !busy_o) else $error("bus reset kept link"); // R6
endmodule

// File: rtl/scsi_int_latch.sv
module scsi_int_latch #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic         rd_i,
  input  logic         clr_all_i,
  output logic [W-1:0] stat_o,
  output logic         irq_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        q <= '0;
    else if (clr_all_i) q <= '0;
    else                q <= (rd_i ? '0 : q) | set_i;
  end

  assign stat_o = q;
  assign irq_o  = |q;

  AST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i && !clr_all_i |=> (($past(stat_o) & ~stat_o) == '0)) else $error("status bit lost"); // R12
  AST_RD_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && set_i == '0 |=> stat_o == '0) else $error("read did not clear"); // R12
  AST_CHIPRST_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_all_i |=> !irq_o) else $error("chip reset left irq"); // R11
endmodule

// File: rtl/scsi_cmd_decoder.sv
module scsi_cmd_decoder
  import scsi_cmd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic              rst_int_dis_i,
  input  logic              done_i,
  input  logic              done_ok_i,
  input  logic              reselect_i,
  input  logic              rd_i,
  output logic              start_o,
  output logic [CODE_W-1:0] act_code_o,
  output logic              act_dma_o,
  output logic              flush_o,
  output logic              bus_rst_o,
  output logic              atn_o,
  output logic              busy_o,
  output logic              connected_o,
  output logic [INT_W-1:0]  int_stat_o,
  output logic              irq_o
);
  cls_e             cls;
  kind_e            kind;
  logic [INT_W-1:0] int_set;
  logic             int_clr_all;

  scsi_cmd_classify u_classify (
    .code_i (cmd_i[CODE_W-1:0]),
    .cls_o  (cls),
    .kind_o (kind)
  );

  scsi_conn_fsm u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .cmd_valid_i   (cmd_valid_i),
    .code_i        (cmd_i[CODE_W-1:0]),
    .dma_i         (cmd_i[CMD_W-1]),
    .cls_i         (cls),
    .kind_i        (kind),
    .rst_int_dis_i (rst_int_dis_i),
    .done_i        (done_i),
    .done_ok_i     (done_ok_i),
    .reselect_i    (reselect_i),
    .start_o       (start_o),
    .act_code_o    (act_code_o),
    .act_dma_o     (act_dma_o),
    .flush_o       (flush_o),
    .bus_rst_o     (bus_rst_o),
    .atn_o         (atn_o),
    .busy_o        (busy_o),
    .connected_o   (connected_o),
    .int_set_o     (int_set),
    .int_clr_all_o (int_clr_all)
  );

  scsi_int_latch #(.W(INT_W)) u_int (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (int_set),
    .rd_i      (rd_i),
    .clr_all_i (int_clr_all),
    .stat_o    (int_stat_o),
    .irq_o     (irq_o)
  );

  AST_ILL_NO_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && int_set[IB_ILL] && !done_i |=> $stable(connected_o) && $stable(busy_o))
    else $error("illegal command changed state"); // R5
endmodule

// File: tb/scsi_cmd_decoder_bench.sv
module scsi_cmd_decoder_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0, rst_int_dis = 1'b0, done = 1'b0, done_ok = 1'b0;
  logic       resel = 1'b0, rd = 1'b0;
  logic [7:0] cmd = '0;
  logic       start, act_dma, flush, bus_rst, atn, busy, conn, irq;
  logic [6:0] act_code;
  logic [7:0] int_stat;
  int tests = 0, fails = 0;

  always #4 clk = ~clk;

  scsi_cmd_decoder u_scsi_cmd_decoder (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_i(cmd),
    .rst_int_dis_i(rst_int_dis), .done_i(done), .done_ok_i(done_ok),
    .reselect_i(resel), .rd_i(rd), .start_o(start), .act_code_o(act_code),
    .act_dma_o(act_dma), .flush_o(flush), .bus_rst_o(bus_rst), .atn_o(atn),
    .busy_o(busy), .connected_o(conn), .int_stat_o(int_stat), .irq_o(irq)
  );

  // {op, value, expected status, expected connected}; op 0 cmd, 1 done ok, 2 done fail, 3 reselect
  localparam int NV = 25;
  localparam logic [18:0] VEC [NV] = '{
    {2'd0, 8'h10, 8'h40, 1'b0},  // R5 transfer while disconnected
    {2'd0, 8'h00, 8'h00, 1'b0},  // R3 no-op
    {2'd0, 8'h03, 8'h80, 1'b0},  // R6 bus reset interrupt
    {2'd0, 8'h44, 8'h00, 1'b0},  // R7 arm reselection
    {2'd0, 8'h45, 8'h08, 1'b0},  // R7 disarm -> function complete
    {2'd3, 8'h00, 8'h00, 1'b0},  // R10 reselect ignored when disarmed
    {2'd0, 8'h44, 8'h00, 1'b0},  // R7
    {2'd3, 8'h00, 8'h04, 1'b1},  // R10 reselected
    {2'd0, 8'h42, 8'h40, 1'b1},  // R4 select while connected
    {2'd0, 8'h1A, 8'h00, 1'b1},  // R7 set ATN silent
    {2'd0, 8'h1B, 8'h00, 1'b1},  // R7 clear ATN silent
    {2'd0, 8'h91, 8'h00, 1'b1},  // R2 complete sequence with DMA bit
    {2'd0, 8'h12, 8'h40, 1'b1},  // R5 gated command while busy
    {2'd1, 8'h00, 8'h08, 1'b1},  // R9 complete sequence done
    {2'd0, 8'h10, 8'h00, 1'b1},  // R9
    {2'd1, 8'h00, 8'h10, 1'b1},  // R9 bus service
    {2'd0, 8'h18, 8'h00, 1'b1},  // R9
    {2'd2, 8'h00, 8'h20, 1'b0},  // R9 target dropped
    {2'd0, 8'h2F, 8'h40, 1'b0},  // R5 unknown code
    {2'd0, 8'h41, 8'h00, 1'b0},  // R8
    {2'd0, 8'h01, 8'h00, 1'b0},  // R3 flush while busy
    {2'd2, 8'h00, 8'h20, 1'b0},  // R8 selection timeout
    {2'd0, 8'hC2, 8'h00, 1'b0},  // R2 R8 select with DMA bit
    {2'd1, 8'h00, 8'h18, 1'b1},  // R8 selected
    {2'd0, 8'h02, 8'h00, 1'b0}   // R11 chip reset
  };

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] op, input logic [7:0] v);
    @(negedge clk);
    case (op)
      2'd0: begin cmd = v; cmd_valid = 1'b1; end
      2'd1: begin done = 1'b1; done_ok = 1'b1; end
      2'd2: begin done = 1'b1; done_ok = 1'b0; end
      default: resel = 1'b1;
    endcase
    @(negedge clk);
    cmd_valid = 1'b0; done = 1'b0; done_ok = 1'b0; resel = 1'b0;
  endtask

  task automatic read_clear();
    @(negedge clk); rd = 1'b1;
    @(negedge clk); rd = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    tests++; fails++;
    $display("FAIL R13 watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", "int_stat", int_stat, 8'h00);
    check("R1", "irq", irq, 0);
    check("R1", "conn/busy/atn", {conn, busy, atn}, 3'b000);
    check("R1", "pulses", {start, flush, bus_rst}, 3'b000);

    // R13 vector walk: every result due one edge after the strobe
    for (int i = 0; i < NV; i++) begin
      send(VEC[i][18:17], VEC[i][16:9]);
      check("R13", $sformatf("vec%0d int_stat", i), int_stat, VEC[i][8:1]);
      check("R13", $sformatf("vec%0d connected", i), conn, VEC[i][0]);
      read_clear();
      check("R12", $sformatf("vec%0d cleared", i), int_stat, 8'h00);
    end

    // R2 DMA qualifier on launch
    send(2'd0, 8'hC1);
    check("R2", "start", start, 1);
    check("R2", "act_code", act_code, 7'h41);
    check("R2", "act_dma", act_dma, 1);
    check("R8", "busy", busy, 1);
    @(negedge clk);
    check("R8", "start one cycle", start, 0);
    send(2'd1, 8'h00);
    read_clear();
    // R7 ATN and R9 ATN cleared on failure
    send(2'd0, 8'h1A);
    check("R7", "atn set", atn, 1);
    send(2'd0, 8'h10);
    check("R2", "act_dma low", act_dma, 0);
    send(2'd2, 8'h00);
    check("R9", "atn cleared", atn, 0);
    check("R9", "disconnected", conn, 0);
    read_clear();

    // R6 disabled reset interrupt
    send(2'd0, 8'h41); send(2'd1, 8'h00); read_clear();
    rst_int_dis = 1'b1;
    send(2'd0, 8'h03);
    check("R6", "bus_rst pulse", bus_rst, 1);
    check("R6", "no reset int", int_stat, 8'h00);
    check("R6", "disconnected", conn, 0);
    rst_int_dis = 1'b0;

    // R3 flush pulse
    send(2'd0, 8'h81);
    check("R3", "flush pulse", flush, 1);
    check("R3", "no int", int_stat, 8'h00);

    // R11 chip reset clears everything
    send(2'd0, 8'h44);
    send(2'd3, 8'h00);
    send(2'd0, 8'h1A);
    send(2'd0, 8'h7F);
    check("R12", "irq set", irq, 1);
    send(2'd0, 8'h02);
    check("R11", "int cleared", int_stat, 8'h00);
    check("R11", "conn/busy/atn", {conn, busy, atn}, 3'b000);
    send(2'd3, 8'h00);
    check("R11", "resel disarmed", {conn, int_stat}, 9'h000);

    // R12 read and set in the same cycle
    send(2'd0, 8'h45);
    check("R12", "fc set", int_stat, 8'h08);
    @(negedge clk); rd = 1'b1; cmd = 8'h2F; cmd_valid = 1'b1;
    @(negedge clk); rd = 1'b0; cmd_valid = 1'b0;
    check("R12", "new bit survives read", int_stat, 8'h40);
    check("R12", "irq", irq, 1);
    read_clear();
    check("R12", "irq low", irq, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule